// File: doc/BRIEF.md
# Display RAM Buffered Write Port

This block lets a processor place a 16-bit character word into the character memory of an on-screen display while the display engine keeps reading that memory for the picture. Software sets a row address and a column address, then loads the word as two bytes, the high byte first and the low byte second. Writing the low byte takes a snapshot of the address and both bytes and marks a transfer as pending. The snapshot is held until the display engine signals a free memory slot with a one-cycle grant. In that cycle the block drives the memory write strobe together with the held address and word.

A write-ready flag tells software when the held word has reached memory. A second flag is set when the display engine finishes showing row 15, the last row. Software uses it to learn when direct updates are safe. Software clears this flag by writing 0 to it. An interrupt request follows the flag when its enable bit is set.

The transfer path is a two-state machine. In `ST_READY` nothing is pending. A low-byte write moves it to `ST_PENDING` (transition LOAD). In `ST_PENDING`, another low-byte write keeps the state and replaces the held word (transition RELOAD). A grant with no low-byte write in the same cycle returns it to `ST_READY` (transition COMMIT). Without either event the state holds (transition WAIT).

The display-end flag is a second two-state machine. `DE_CLEAR` moves to `DE_SET` on the row-15 end event (transition FRAME_END). `DE_SET` returns to `DE_CLEAR` on a status write with bit 1 equal to 0 (transition SW_CLEAR), unless a row-15 end event arrives in the same cycle, in which case the flag stays set.

Register select codes are: 0 row address, 1 column address, 2 data high byte, 3 data low byte, 4 status and control. In the status register, bit 0 is write-ready (read only), bit 1 is the display-end flag, and bit 2 is the interrupt enable. The memory address is the row address concatenated above the column address, `{row, col}`.

Top module: `osd_wr_port`

## Requirements
- R1: After reset, write-ready (status bit 0) reads 1, the display-end flag (status bit 1) reads 0, the interrupt enable (status bit 2) reads 0, and `ram_we` and `irq` are 0.
- R2: A write to the data high byte (select 2) alone starts no transfer. `ram_we` stays 0 even when `grant` is asserted, and write-ready stays 1.
- R3: A write to the data low byte (select 3) makes write-ready read 0 from the cycle after the write.
- R4: `ram_we` is 1 only in a cycle where `grant` is 1 while a transfer is pending. In that cycle `ram_addr` equals `{row, col}` and `ram_wdata` equals `{high, low}`, as both stood at the low-byte write. Each pending transfer produces exactly one write.
- R5: Write-ready reads 1 again from the cycle after the commit cycle. A later `grant` produces no further write.
- R6: A low-byte write while a transfer is pending replaces the held address and word, and only one memory write follows. A `grant` in the same cycle as a low-byte write commits nothing.
- R7: The display-end flag is set in the cycle after `row_end` is 1 with `row_idx` equal to 15. A `row_end` with any other row index leaves the flag unchanged.
- R8: A status write (select 4) with bit 1 equal to 0 clears the display-end flag. With bit 1 equal to 1, the write leaves the flag unchanged. A set event in the same cycle as a clear wins.
- R9: `irq` is 1 exactly when the display-end flag and the interrupt enable are both 1.
- R10: Changing the row, column or data byte registers after a low-byte write does not alter the pending address or word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current select |
| grant | input | 1 | One-cycle memory slot grant from the display engine |
| row_end | input | 1 | Pulse at the end of a displayed character row |
| row_idx | input | 4 | Index of the row that just ended |
| ram_we | output | 1 | Character memory write strobe |
| ram_addr | output | 9 | Character memory address `{row, col}` |
| ram_wdata | output | 16 | Character memory write word |
| irq | output | 1 | Display-end interrupt request |

## Verification
The hardest case to reach is the collision of a grant with a low-byte write while a transfer is already pending. A correct design must let the newer word win and must not write twice. The stimulus reaches this case by holding the grant in the same cycle as a second low-byte write, then granting again. A write counter in the bench confirms that exactly one write carries the second word. A full sweep over every row and column also varies the wait between the low-byte write and the grant. This exposes any path where a stale snapshot or the live registers leak onto the memory bus.

// File: rtl/osd_wr_pkg.sv
package osd_wr_pkg;
    typedef enum logic [2:0] {
        SEL_ROW  = 3'd0,
        SEL_COL  = 3'd1,
        SEL_HIGH = 3'd2,
        SEL_LOW  = 3'd3,
        SEL_CTL  = 3'd4
    } reg_sel_e;

    typedef enum logic {
        ST_READY   = 1'b0,
        ST_PENDING = 1'b1
    } xfer_state_e;

    typedef enum logic {
        DE_CLEAR = 1'b0,
        DE_SET   = 1'b1
    } dend_state_e;

    localparam int CTL_READY_BIT = 0;
    localparam int CTL_DEND_BIT  = 1;
    localparam int CTL_IEN_BIT   = 2;
endpackage

// File: rtl/osd_wr_regs.sv
module osd_wr_regs
    import osd_wr_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              wr_ready,
    input  logic              dend_flag,
    output logic [ROW_W-1:0]  row_q,
    output logic [COL_W-1:0]  col_q,
    output logic [BYTE_W-1:0] high_q,
    output logic              low_wr,
    output logic              ctl_wr,
    output logic              irq_en
);
    logic [BYTE_W-1:0] low_q;
    logic              row_wr;
    logic              col_wr;
    logic              high_wr;

    always_comb begin
        row_wr  = reg_we && (reg_sel == SEL_ROW);
        col_wr  = reg_we && (reg_sel == SEL_COL);
        high_wr = reg_we && (reg_sel == SEL_HIGH);
        low_wr  = reg_we && (reg_sel == SEL_LOW);
        ctl_wr  = reg_we && (reg_sel == SEL_CTL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q  <= '0;
            col_q  <= '0;
            irq_en <= 1'b0;
        end else begin
            if (row_wr) begin
                row_q <= reg_wdata[ROW_W-1:0];
            end
            if (col_wr) begin
                col_q <= reg_wdata[COL_W-1:0];
            end
            if (ctl_wr) begin
                irq_en <= reg_wdata[CTL_IEN_BIT];
            end
        end
    end

    // data byte registers keep their contents through reset
    always_ff @(posedge clk) begin
        if (high_wr) begin
            high_q <= reg_wdata;
        end
        if (low_wr) begin
            low_q <= reg_wdata;
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_ROW:  reg_rdata[ROW_W-1:0] = row_q;
            SEL_COL:  reg_rdata[COL_W-1:0] = col_q;
            SEL_HIGH: reg_rdata = high_q;
            SEL_LOW:  reg_rdata = low_q;
            SEL_CTL: begin
                reg_rdata[CTL_READY_BIT] = wr_ready;
                reg_rdata[CTL_DEND_BIT]  = dend_flag;
                reg_rdata[CTL_IEN_BIT]   = irq_en;
            end
            default:  reg_rdata = '0;
        endcase
    end

    // R1
    row_reset_chk: assert property (@(posedge clk) $rose(rst_n) |-> (row_q == '0 && col_q == '0 && !irq_en));
endmodule

// File: rtl/osd_wr_xfer.sv
module osd_wr_xfer
    import osd_wr_pkg::*;
#(
    parameter int ROW_W  = 4,
    parameter int COL_W  = 5,
    parameter int BYTE_W = 8,
    localparam int ADDR_W = ROW_W + COL_W,
    localparam int WORD_W = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              low_wr,
    input  logic [BYTE_W-1:0] low_byte,
    input  logic [ROW_W-1:0]  row_q,
    input  logic [COL_W-1:0]  col_q,
    input  logic [BYTE_W-1:0] high_q,
    input  logic              grant,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              wr_ready
);
    xfer_state_e       state_q;
    xfer_state_e       state_d;
    logic [ADDR_W-1:0] addr_hold;
    logic [WORD_W-1:0] word_hold;

    // next-state decision: LOAD, RELOAD, COMMIT, WAIT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY: begin
                if (low_wr) begin
                    state_d = ST_PENDING;
                end
            end
            ST_PENDING: begin
                if (low_wr) begin
                    state_d = ST_PENDING;
                end else if (grant) begin
                    state_d = ST_READY;
                end
            end
            default: state_d = ST_READY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_READY;
        end else begin
            state_q <= state_d;
        end
    end

    // snapshot taken on every low byte write
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_hold <= '0;
            word_hold <= '0;
        end else if (low_wr) begin
            addr_hold <= {row_q, col_q};
            word_hold <= {high_q, low_byte};
        end
    end

    // outputs
    always_comb begin
        ram_we    = 1'b0;
        wr_ready  = 1'b1;
        ram_addr  = addr_hold;
        ram_wdata = word_hold;
        unique case (state_q)
            ST_READY: begin
                wr_ready = 1'b1;
            end
            ST_PENDING: begin
                wr_ready = 1'b0;
                ram_we   = grant && !low_wr;
            end
            default: begin
                wr_ready = 1'b1;
            end
        endcase
    end

    // R3
    low_clears_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) low_wr |=> !wr_ready);
    // R5
    commit_sets_ready_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_we |=> wr_ready);
    // R4
    write_needs_grant_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_we |-> (grant && !wr_ready));
    // R6
    no_write_on_reload_chk: assert property (@(posedge clk) disable iff (!rst_n) low_wr |-> !ram_we);
    // R10
    held_word_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_ready && !low_wr) |=> ($stable(ram_addr) && $stable(ram_wdata)));
endmodule

// File: rtl/osd_wr_dend.sv
module osd_wr_dend
    import osd_wr_pkg::*;
#(
    parameter int RIDX_W   = 4,
    parameter int LAST_ROW = 15
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              row_end,
    input  logic [RIDX_W-1:0] row_idx,
    input  logic              ctl_wr,
    input  logic              keep_bit,
    input  logic              irq_en,
    output logic              dend_flag,
    output logic              irq
);
    localparam logic [RIDX_W-1:0] LAST_IDX = RIDX_W'(LAST_ROW);

    dend_state_e state_q;
    dend_state_e state_d;
    logic        frame_end;
    logic        sw_clear;

    always_comb begin
        frame_end = row_end && (row_idx == LAST_IDX);
        sw_clear  = ctl_wr && !keep_bit;
    end

    // FRAME_END and SW_CLEAR; a set event wins over a clear
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DE_CLEAR: begin
                if (frame_end) begin
                    state_d = DE_SET;
                end
            end
            DE_SET: begin
                if (sw_clear && !frame_end) begin
                    state_d = DE_CLEAR;
                end
            end
            default: state_d = DE_CLEAR;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DE_CLEAR;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        dend_flag = 1'b0;
        unique case (state_q)
            DE_CLEAR: dend_flag = 1'b0;
            DE_SET:   dend_flag = 1'b1;
            default:  dend_flag = 1'b0;
        endcase
        irq = dend_flag && irq_en;
    end

    // R7
    flag_rise_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dend_flag) |-> $past(row_end && row_idx == LAST_IDX));
    // R7
    frame_end_sets_chk: assert property (@(posedge clk) disable iff (!rst_n) frame_end |=> dend_flag);
    // R8
    keep_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && keep_bit && !frame_end) |=> $stable(dend_flag));
    // R8
    clear_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_wr && !keep_bit && !frame_end) |=> !dend_flag);
endmodule

// File: rtl/osd_wr_port.sv
module osd_wr_port
    import osd_wr_pkg::*;
#(
    parameter int ROW_W    = 4,
    parameter int COL_W    = 5,
    parameter int BYTE_W   = 8,
    parameter int LAST_ROW = 15,
    localparam int ADDR_W  = ROW_W + COL_W,
    localparam int WORD_W  = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [BYTE_W-1:0] reg_wdata,
    output logic [BYTE_W-1:0] reg_rdata,
    input  logic              grant,
    input  logic              row_end,
    input  logic [ROW_W-1:0]  row_idx,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [WORD_W-1:0] ram_wdata,
    output logic              irq
);
    logic [ROW_W-1:0]  row_q;
    logic [COL_W-1:0]  col_q;
    logic [BYTE_W-1:0] high_q;
    logic              low_wr;
    logic              ctl_wr;
    logic              irq_en;
    logic              wr_ready;
    logic              dend_flag;

    osd_wr_regs #(.ROW_W(ROW_W), .COL_W(COL_W), .BYTE_W(BYTE_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_we    (reg_we),
        .reg_sel   (reg_sel),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .wr_ready  (wr_ready),
        .dend_flag (dend_flag),
        .row_q     (row_q),
        .col_q     (col_q),
        .high_q    (high_q),
        .low_wr    (low_wr),
        .ctl_wr    (ctl_wr),
        .irq_en    (irq_en)
    );

    osd_wr_xfer #(.ROW_W(ROW_W), .COL_W(COL_W), .BYTE_W(BYTE_W)) u_xfer (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_wr    (low_wr),
        .low_byte  (reg_wdata),
        .row_q     (row_q),
        .col_q     (col_q),
        .high_q    (high_q),
        .grant     (grant),
        .ram_we    (ram_we),
        .ram_addr  (ram_addr),
        .ram_wdata (ram_wdata),
        .wr_ready  (wr_ready)
    );

    osd_wr_dend #(.RIDX_W(ROW_W), .LAST_ROW(LAST_ROW)) u_dend (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_end   (row_end),
        .row_idx   (row_idx),
        .ctl_wr    (ctl_wr),
        .keep_bit  (reg_wdata[CTL_DEND_BIT]),
        .irq_en    (irq_en),
        .dend_flag (dend_flag),
        .irq       (irq)
    );

    // R2
    high_keeps_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_we && reg_sel == SEL_HIGH && wr_ready) |=> wr_ready);
    // R9
    irq_needs_flag_chk: assert property (@(posedge clk) disable iff (!rst_n) irq |-> dend_flag);
endmodule

// File: tb/osd_wr_port_tb.sv
module osd_wr_port_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = 3'd0;
    logic [7:0]  reg_wdata = 8'd0;
    logic [7:0]  reg_rdata;
    logic        grant = 1'b0;
    logic        row_end = 1'b0;
    logic [3:0]  row_idx = 4'd0;
    logic        ram_we;
    logic [8:0]  ram_addr;
    logic [15:0] ram_wdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    int wr_count = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (rst_n && ram_we) wr_count <= wr_count + 1;

    osd_wr_port u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .grant(grant),
        .row_end(row_end), .row_idx(row_idx), .ram_we(ram_we),
        .ram_addr(ram_addr), .ram_wdata(ram_wdata), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_sel = s; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] s, output logic [7:0] d);
        reg_sel = s;
        #1 d = reg_rdata;
    endtask

    task automatic pulse_grant(input string req, input int exp_we,
                               input int exp_addr, input int exp_data);
        @(negedge clk);
        grant = 1'b1;
        #1;
        chk(req, ram_we, exp_we);
        if (exp_we == 1) begin
            chk(req, ram_addr, exp_addr);
            chk(req, ram_wdata, exp_data);
        end
        @(negedge clk);
        grant = 1'b0;
    endtask

    task automatic row_pulse(input logic [3:0] idx);
        @(negedge clk);
        row_end = 1'b1; row_idx = idx;
        @(negedge clk);
        row_end = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=1 expected=0");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] st;
        logic [7:0] hb;
        logic [7:0] lb;
        int         base;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        rd(3'd4, st);
        chk("R1", st[2:0], 3'b001);
        chk("R1", ram_we, 0);
        chk("R1", irq, 0);

        // R2 high byte alone
        wr(3'd2, 8'h5a);
        rd(3'd4, st);
        chk("R2", st[0], 1);
        pulse_grant("R2", 0, 0, 0);

        // sweep all rows and columns: R3 R4 R5
        for (int r = 0; r < 16; r++) begin
            for (int c = 0; c < 32; c++) begin
                hb = 8'((r * 7 + c * 3) & 255);
                lb = 8'((c * 13 + r * 5 + 1) & 255);
                wr(3'd0, 8'(r));
                wr(3'd1, 8'(c));
                wr(3'd2, hb);
                wr(3'd3, lb);
                rd(3'd4, st);
                chk("R3", st[0], 0);
                base = wr_count;
                repeat ((r + c) % 3) @(negedge clk);
                pulse_grant("R4", 1, (r << 5) | c, {hb, lb});
                rd(3'd4, st);
                chk("R5", st[0], 1);
                pulse_grant("R5", 0, 0, 0);
                chk("R4", wr_count - base, 1);
            end
        end

        // R6 reload while pending, grant colliding with low write
        wr(3'd0, 8'd3); wr(3'd1, 8'd9); wr(3'd2, 8'h11); wr(3'd3, 8'h22);
        wr(3'd0, 8'd12); wr(3'd1, 8'd30); wr(3'd2, 8'hab);
        base = wr_count;
        @(negedge clk);
        reg_sel = 3'd3; reg_wdata = 8'hcd; reg_we = 1'b1; grant = 1'b1;
        #1 chk("R6", ram_we, 0);
        @(negedge clk);
        reg_we = 1'b0; grant = 1'b0;
        rd(3'd4, st);
        chk("R6", st[0], 0);
        pulse_grant("R6", 1, (12 << 5) | 30, 16'habcd);
        pulse_grant("R6", 0, 0, 0);
        chk("R6", wr_count - base, 1);

        // R10 register changes after low write do not alter held word
        wr(3'd0, 8'd5); wr(3'd1, 8'd17); wr(3'd2, 8'h3c); wr(3'd3, 8'hc3);
        wr(3'd0, 8'd14); wr(3'd1, 8'd2); wr(3'd2, 8'hff);
        pulse_grant("R10", 1, (5 << 5) | 17, 16'h3cc3);

        // R7 display end flag only on row 15
        for (int i = 0; i < 15; i++) begin
            row_pulse(4'(i));
            rd(3'd4, st);
            chk("R7", st[1], 0);
        end
        row_pulse(4'd15);
        rd(3'd4, st);
        chk("R7", st[1], 1);
        chk("R9", irq, 0);

        // R9 enable drives irq; writing 1 to flag keeps it (R8)
        wr(3'd4, 8'b0000_0110);
        rd(3'd4, st);
        chk("R8", st[1], 1);
        chk("R9", irq, 1);
        // R8 clear by writing 0
        wr(3'd4, 8'b0000_0100);
        rd(3'd4, st);
        chk("R8", st[1], 0);
        chk("R9", irq, 0);
        // R8 writing 1 while clear does not set
        wr(3'd4, 8'b0000_0110);
        rd(3'd4, st);
        chk("R8", st[1], 0);
        // R8 set wins over simultaneous clear
        @(negedge clk);
        reg_sel = 3'd4; reg_wdata = 8'b0000_0100; reg_we = 1'b1;
        row_end = 1'b1; row_idx = 4'd15;
        @(negedge clk);
        reg_we = 1'b0; row_end = 1'b0;
        rd(3'd4, st);
        chk("R8", st[1], 1);
        chk("R9", irq, 1);
        // R9 enable off masks irq
        wr(3'd4, 8'b0000_0010);
        rd(3'd4, st);
        chk("R9", st[2:1], 2'b01);
        chk("R9", irq, 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule